// File: doc/BRIEF.md
# Spare Allocation Strategy Solver

This block runs after a memory test has finished and a must-repair pass has already fixed some spare rows and spare columns. It searches for the cheapest way to spend the spares that are left, so that every fault recorded in a fault list ends up on a replaced row or a replaced column. A candidate is a strategy word with one symbol per remaining spare: a 1 means "use a spare row" and a 0 means "use a spare column". The solver walks the fault list from its first entry. Each entry that the partial solution does not yet cover takes the next unused symbol, and the matching address is written into a small solution record.

A strategy is dropped as soon as it would overflow a spare kind, or as soon as its spare count can no longer beat the best complete strategy found so far. An external enumerator supplies the next strategy word. Only the best strategy word and its cost are kept. When the last strategy has been tried, a recovery pass replays the best word once more, so the solution record ends up holding the winning addresses.

Top module: `sa_solver`

## Requirements
- R1: After reset the solver is idle: `busy`, `done`, `unrep`, `restart`, `row_ins` and `col_ins` are all low.
- R2: On `start`, the first strategy has length equal to the spare rows plus spare columns still free after must-repair. Its value is the one with the free-row count of 1 bits in the lowest positions, where 1 means row and 0 means column.
- R3: Fault-list entries are read from index 0 upward. An entry already covered by a recorded row or column causes no insert. Otherwise the k-th insert since the last rewind uses strategy bit k (bit 0 first): `row_ins` if that bit is 1, and `col_ins` if it is 0.
- R4: An insert that would target a full spare kind abandons the strategy. `restart` pulses, and the fault-list index reads 0 on the next cycle.
- R5: No insert is made that would bring the spare count to or above the best complete cost found so far (outside the recovery pass). Such a strategy is abandoned with `restart` instead.
- R6: A strategy that reaches the end of the fault list with a cost below the best so far becomes the new best; `best_strat` and `best_cost` hold it.
- R7: Each strategy, including its advance cycle, occupies at most fault-count + 1 cycles, and never more than 2·M·N + 1.
- R8: After `done` on a repairable map, the solution record holds the must-repair addresses plus the recovered addresses, covers every fault, and holds exactly `best_cost` entries.
- R9: `best_cost` at `done` equals the minimum spare count over all valid repairs.
- R10: If no strategy covers all faults, `done` rises together with `unrep`.
- R11: On every rewind, the solution record counts return to the must-repair counts latched at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted when not busy) |
| mr_rows | input | M*RW | Must-repair row addresses, entry j at bits j*RW |
| mr_rcnt | input | clog2(M+1) | Number of valid must-repair rows |
| mr_cols | input | N*CW | Must-repair column addresses |
| mr_ccnt | input | clog2(N+1) | Number of valid must-repair columns |
| flt_cnt | input | clog2(2MN+1) | Number of fault-list entries |
| flt_idx | output | clog2(2MN+1) | Fault-list read index |
| flt_row | input | RW | Row address of the entry at `flt_idx` |
| flt_col | input | CW | Column address of the entry at `flt_idx` |
| cur_strat | output | M+N | Strategy word under evaluation |
| strat_len | output | clog2(M+N+1) | Number of symbols in the strategy |
| nxt_strat | input | M+N | Enumerator's successor of `cur_strat` |
| nxt_valid | input | 1 | A successor exists |
| row_ins | output | 1 | Row address being added to the record |
| col_ins | output | 1 | Column address being added to the record |
| restart | output | 1 | Rewind pulse (next strategy or recovery) |
| busy | output | 1 | Search or recovery in progress |
| done | output | 1 | Search finished |
| unrep | output | 1 | No valid repair exists |
| best_cost | output | clog2(M+N+2) | Spare count of the best strategy (all ones before any success) |
| best_strat | output | M+N | Best strategy word |
| sol_rows | output | M*RW | Solution record rows |
| sol_rcnt | output | clog2(M+1) | Valid solution rows |
| sol_cols | output | N*CW | Solution record columns |
| sol_ccnt | output | clog2(N+1) | Valid solution columns |

## Verification
The assertions take the following for granted. The must-repair counts do not exceed the spare counts. The fault count is at most 2·M·N. The fault list and must-repair inputs stay steady while `busy` is high. `nxt_strat` has the same length and number of row symbols as `cur_strat`. Under these conditions an insert can only overflow once every symbol has been spent, and the recovery replay cannot fail. The stimulus meets all of this: the bench holds fixed vectors with small fault maps and legal must-repair counts, and its enumerator model steps through equal-weight words in rising order within `strat_len` bits.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_FIN} sa_state_e;

    typedef struct packed {
        logic step;
        logic ins_r;
        logic ins_c;
        logic adv;
        logic fin;
    } sa_act_t;
endpackage

// File: rtl/sa_record.sv
module sa_record #(
    parameter int M  = 2,
    parameter int N  = 2,
    parameter int RW = 4,
    parameter int CW = 4,
    localparam int RCW = $clog2(M + 1),
    localparam int CCW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [M*RW-1:0] ld_rows,
    input  logic [RCW-1:0]  ld_rcnt,
    input  logic [N*CW-1:0] ld_cols,
    input  logic [CCW-1:0]  ld_ccnt,
    input  logic            restore,
    input  logic            ins_row,
    input  logic            ins_col,
    input  logic [RW-1:0]   probe_row,
    input  logic [CW-1:0]   probe_col,
    output logic            row_hit,
    output logic            col_hit,
    output logic [RCW-1:0]  row_cnt,
    output logic [CCW-1:0]  col_cnt,
    output logic [RCW-1:0]  sv_rcnt,
    output logic [CCW-1:0]  sv_ccnt,
    output logic [M*RW-1:0] rows_q,
    output logic [N*CW-1:0] cols_q
);
    logic [M-1:0] rmatch;
    logic [N-1:0] cmatch;

    for (genvar gi = 0; gi < M; gi++) begin : g_row
        logic [RW-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (load)
                ent_q <= ld_rows[gi*RW +: RW];
            else if (ins_row && row_cnt == RCW'(gi))
                ent_q <= probe_row;
        end
        assign rmatch[gi] = (RCW'(gi) < row_cnt) && (ent_q == probe_row);
        assign rows_q[gi*RW +: RW] = ent_q;
    end

    for (genvar gj = 0; gj < N; gj++) begin : g_col
        logic [CW-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (load)
                ent_q <= ld_cols[gj*CW +: CW];
            else if (ins_col && col_cnt == CCW'(gj))
                ent_q <= probe_col;
        end
        assign cmatch[gj] = (CCW'(gj) < col_cnt) && (ent_q == probe_col);
        assign cols_q[gj*CW +: CW] = ent_q;
    end

    assign row_hit = |rmatch;
    assign col_hit = |cmatch;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_cnt <= '0;
            col_cnt <= '0;
            sv_rcnt <= '0;
            sv_ccnt <= '0;
        end else if (load) begin
            row_cnt <= ld_rcnt;
            col_cnt <= ld_ccnt;
            sv_rcnt <= ld_rcnt;
            sv_ccnt <= ld_ccnt;
        end else if (restore) begin
            row_cnt <= sv_rcnt;
            col_cnt <= sv_ccnt;
        end else begin
            if (ins_row) row_cnt <= row_cnt + RCW'(1);
            if (ins_col) col_cnt <= col_cnt + CCW'(1);
        end
    end

    // R4: a row insert never lands in a full row record
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        ins_row |-> (row_cnt < RCW'(M)));
    // R4: a column insert never lands in a full column record
    assert_no_col_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        ins_col |-> (col_cnt < CCW'(N)));
    // R11: a rewind brings both counts back to the latched must-repair counts
    assert_restore_R11: assert property (@(posedge clk) disable iff (rst)
        (restore && !load) |=> (row_cnt == sv_rcnt && col_cnt == sv_ccnt));
endmodule

// File: rtl/sa_strat.sv
module sa_strat #(
    parameter int SW = 4,
    localparam int LW = $clog2(SW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_first,
    input  logic [LW-1:0] first_ones,
    input  logic [LW-1:0] first_len,
    input  logic          ld_other,
    input  logic [SW-1:0] other,
    input  logic [LW-1:0] idx,
    output logic [SW-1:0] strat_q,
    output logic [LW-1:0] len_q,
    output logic          sym
);
    logic [SW-1:0] pat;

    always_comb begin
        for (int i = 0; i < SW; i++)
            pat[i] = (LW'(i) < first_ones);
    end

    always_comb begin
        sym = 1'b1;
        for (int i = 0; i < SW; i++)
            if (LW'(i) == idx && idx < len_q)
                sym = strat_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strat_q <= '0;
            len_q   <= '0;
        end else if (ld_first) begin
            strat_q <= pat;
            len_q   <= first_len;
        end else if (ld_other) begin
            strat_q <= other;
        end
    end

    // R2: the first strategy carries exactly the free-row count of row symbols
    assert_first_ones_R2: assert property (@(posedge clk) disable iff (rst)
        ld_first |=> ($countones(strat_q) == int'($past(first_ones))));
    // R2: the first strategy has the requested length
    assert_first_len_R2: assert property (@(posedge clk) disable iff (rst)
        ld_first |=> (len_q == $past(first_len)));
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int M = 2,
    parameter int N = 2,
    localparam int SW   = M + N,
    localparam int LW   = $clog2(SW + 1),
    localparam int RCW  = $clog2(M + 1),
    localparam int CCW  = $clog2(N + 1),
    localparam int FMAX = 2 * M * N,
    localparam int FW   = $clog2(FMAX + 1),
    localparam int KW   = $clog2(M + N + 2)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [FW-1:0]  flt_cnt,
    input  logic           row_hit,
    input  logic           col_hit,
    input  logic [RCW-1:0] row_cnt,
    input  logic [CCW-1:0] col_cnt,
    input  logic [RCW-1:0] sv_rcnt,
    input  logic [CCW-1:0] sv_ccnt,
    input  logic           sym,
    input  logic [SW-1:0]  strat_q,
    input  logic [SW-1:0]  nxt_strat,
    input  logic           nxt_valid,
    output logic           go,
    output logic [FW-1:0]  flt_idx,
    output logic [LW-1:0]  idx,
    output logic           ins_row,
    output logic           ins_col,
    output logic           restart,
    output logic [SW-1:0]  other_val,
    output logic           busy,
    output logic           done,
    output logic           unrep,
    output logic [KW-1:0]  best_cost,
    output logic [SW-1:0]  best_strat
);
    sa_state_e     st_q;
    logic [FW-1:0] ptr_q;
    logic [FW:0]   cyc_q;
    logic          recov_q, bok_q, unrep_q;
    logic [KW-1:0] bcost_q;
    logic [SW-1:0] bstrat_q;

    sa_act_t       act;
    logic          rec, full, worse, nb_ok;
    logic [KW-1:0] cost, nb_cost;
    logic [SW-1:0] nb_strat;

    assign cost = KW'(row_cnt) + KW'(col_cnt);
    assign idx  = LW'(RCW'(row_cnt - sv_rcnt)) + LW'(CCW'(col_cnt - sv_ccnt));

    always_comb begin
        act   = '0;
        rec   = 1'b0;
        go    = 1'b0;
        full  = 1'b0;
        worse = 1'b0;
        case (st_q)
            ST_EVAL: begin
                if (ptr_q < flt_cnt) begin
                    if (row_hit || col_hit) begin
                        act.step = 1'b1;
                    end else begin
                        full  = sym ? (row_cnt == RCW'(M)) : (col_cnt == CCW'(N));
                        worse = !recov_q && bok_q && ((cost + KW'(1)) >= bcost_q);
                        if (full || worse) begin
                            act.adv = 1'b1;
                        end else begin
                            act.step  = 1'b1;
                            act.ins_r = sym;
                            act.ins_c = !sym;
                        end
                    end
                end else if (recov_q) begin
                    act.fin = 1'b1;
                end else begin
                    act.adv = 1'b1;
                    rec     = !bok_q || (cost < bcost_q);
                end
            end
            default: go = start;
        endcase
    end

    always_comb begin
        nb_ok    = bok_q;
        nb_cost  = bcost_q;
        nb_strat = bstrat_q;
        if (rec) begin
            nb_ok    = 1'b1;
            nb_cost  = cost;
            nb_strat = strat_q;
        end
    end

    assign restart   = act.adv && (nxt_valid || nb_ok);
    assign other_val = nxt_valid ? nxt_strat : nb_strat;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ptr_q    <= '0;
            cyc_q    <= '0;
            recov_q  <= 1'b0;
            bok_q    <= 1'b0;
            unrep_q  <= 1'b0;
            bcost_q  <= '1;
            bstrat_q <= '0;
        end else if (go) begin
            st_q     <= ST_EVAL;
            ptr_q    <= '0;
            cyc_q    <= '0;
            recov_q  <= 1'b0;
            bok_q    <= 1'b0;
            unrep_q  <= 1'b0;
            bcost_q  <= '1;
            bstrat_q <= '0;
        end else if (st_q == ST_EVAL) begin
            bok_q    <= nb_ok;
            bcost_q  <= nb_cost;
            bstrat_q <= nb_strat;
            if (restart) begin
                ptr_q <= '0;
                cyc_q <= '0;
                if (!nxt_valid) recov_q <= 1'b1;
            end else if (act.adv) begin
                st_q    <= ST_FIN;
                unrep_q <= 1'b1;
            end else if (act.fin) begin
                st_q <= ST_FIN;
            end else if (act.step) begin
                ptr_q <= ptr_q + FW'(1);
                cyc_q <= cyc_q + (FW+1)'(1);
            end
        end
    end

    assign flt_idx    = ptr_q;
    assign ins_row    = act.ins_r;
    assign ins_col    = act.ins_c;
    assign busy       = (st_q == ST_EVAL);
    assign done       = (st_q == ST_FIN);
    assign unrep      = unrep_q;
    assign best_cost  = bcost_q;
    assign best_strat = bstrat_q;

    // R3: a row insert grows the row record by exactly one entry
    assert_insert_grows_R3: assert property (@(posedge clk) disable iff (rst)
        ins_row |=> (row_cnt == $past(row_cnt) + RCW'(1)));
    // R4: a rewind returns the read index to the first fault entry
    assert_rewind_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (flt_idx == '0));
    // R5: after any search-phase insert the cost is still below the best
    assert_prune_R5: assert property (@(posedge clk) disable iff (rst)
        ((ins_row || ins_col) && bok_q && !recov_q) |=> (cost < bcost_q));
    // R7: no strategy walks more entries than the fault list can hold
    assert_strategy_bound_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cyc_q <= (FW+1)'(FMAX)));
    // R8: the recovery replay never abandons
    assert_recovery_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (recov_q && busy) |-> !restart);
    // R10: the unrepairable flag appears only with completion
    assert_unrep_done_R10: assert property (@(posedge clk) disable iff (rst)
        unrep |-> done);
endmodule

// File: rtl/sa_solver.sv
module sa_solver
    import sa_pkg::*;
#(
    parameter int M  = 2,
    parameter int N  = 2,
    parameter int RW = 4,
    parameter int CW = 4,
    localparam int SW   = M + N,
    localparam int LW   = $clog2(SW + 1),
    localparam int RCW  = $clog2(M + 1),
    localparam int CCW  = $clog2(N + 1),
    localparam int FW   = $clog2(2 * M * N + 1),
    localparam int KW   = $clog2(M + N + 2)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [M*RW-1:0] mr_rows,
    input  logic [RCW-1:0]  mr_rcnt,
    input  logic [N*CW-1:0] mr_cols,
    input  logic [CCW-1:0]  mr_ccnt,
    input  logic [FW-1:0]   flt_cnt,
    output logic [FW-1:0]   flt_idx,
    input  logic [RW-1:0]   flt_row,
    input  logic [CW-1:0]   flt_col,
    output logic [SW-1:0]   cur_strat,
    output logic [LW-1:0]   strat_len,
    input  logic [SW-1:0]   nxt_strat,
    input  logic            nxt_valid,
    output logic            row_ins,
    output logic            col_ins,
    output logic            restart,
    output logic            busy,
    output logic            done,
    output logic            unrep,
    output logic [KW-1:0]   best_cost,
    output logic [SW-1:0]   best_strat,
    output logic [M*RW-1:0] sol_rows,
    output logic [RCW-1:0]  sol_rcnt,
    output logic [N*CW-1:0] sol_cols,
    output logic [CCW-1:0]  sol_ccnt
);
    logic           go, row_hit, col_hit, sym;
    logic [RCW-1:0] sv_rcnt;
    logic [CCW-1:0] sv_ccnt;
    logic [LW-1:0]  idx, first_ones, first_len;
    logic [SW-1:0]  other_val;

    assign first_ones = LW'(M) - LW'(mr_rcnt);
    assign first_len  = first_ones + LW'(N) - LW'(mr_ccnt);

    sa_record #(.M(M), .N(N), .RW(RW), .CW(CW)) u_rec (
        .clk(clk), .rst(rst), .load(go),
        .ld_rows(mr_rows), .ld_rcnt(mr_rcnt), .ld_cols(mr_cols), .ld_ccnt(mr_ccnt),
        .restore(restart), .ins_row(row_ins), .ins_col(col_ins),
        .probe_row(flt_row), .probe_col(flt_col),
        .row_hit(row_hit), .col_hit(col_hit),
        .row_cnt(sol_rcnt), .col_cnt(sol_ccnt),
        .sv_rcnt(sv_rcnt), .sv_ccnt(sv_ccnt),
        .rows_q(sol_rows), .cols_q(sol_cols)
    );

    sa_strat #(.SW(SW)) u_strat (
        .clk(clk), .rst(rst),
        .ld_first(go), .first_ones(first_ones), .first_len(first_len),
        .ld_other(restart), .other(other_val), .idx(idx),
        .strat_q(cur_strat), .len_q(strat_len), .sym(sym)
    );

    sa_ctrl #(.M(M), .N(N)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .flt_cnt(flt_cnt),
        .row_hit(row_hit), .col_hit(col_hit),
        .row_cnt(sol_rcnt), .col_cnt(sol_ccnt),
        .sv_rcnt(sv_rcnt), .sv_ccnt(sv_ccnt),
        .sym(sym), .strat_q(cur_strat),
        .nxt_strat(nxt_strat), .nxt_valid(nxt_valid),
        .go(go), .flt_idx(flt_idx), .idx(idx),
        .ins_row(row_ins), .ins_col(col_ins), .restart(restart),
        .other_val(other_val), .busy(busy), .done(done), .unrep(unrep),
        .best_cost(best_cost), .best_strat(best_strat)
    );
endmodule

// File: tb/sim_sa_solver.sv
module sim_sa_solver;
    localparam int M = 2, N = 2, RW = 4, CW = 4;
    localparam int SW = M + N;
    localparam int LW = $clog2(SW + 1);
    localparam int RCW = $clog2(M + 1);
    localparam int CCW = $clog2(N + 1);
    localparam int FW = $clog2(2 * M * N + 1);
    localparam int KW = $clog2(M + N + 2);
    localparam int NV = 11;

    // fault entry e at bits [e*8 +: 8], row in the high nibble, column in the low
    localparam logic [63:0] VF [NV] = '{64'h0, 64'h11, 64'h2211, 64'h22211211,
        64'h332211, 64'h5544332211, 64'h332211, 64'h332211, 64'h1871,
        64'h312111, 64'h33231211};
    localparam int VN [NV]  = '{0, 1, 2, 4, 3, 5, 3, 3, 2, 3, 4};
    localparam logic [7:0] VMR [NV] = '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0,
        8'h07, 8'h07, 8'h87, 8'h87, 8'h0};
    localparam int VRC [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 2, 2, 0};
    localparam logic [7:0] VMC [NV] = '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0,
        8'h0, 8'h07, 8'h87, 8'h0, 8'h0};
    localparam int VCC [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0};
    localparam int VEXP [NV] = '{0, 1, 2, 2, 3, -1, 4, -1, 4, 3, 2};

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [M*RW-1:0] mr_rows = '0;
    logic [RCW-1:0]  mr_rcnt = '0;
    logic [N*CW-1:0] mr_cols = '0;
    logic [CCW-1:0]  mr_ccnt = '0;
    logic [FW-1:0]   flt_cnt = '0, flt_idx;
    logic [RW-1:0]   flt_row;
    logic [CW-1:0]   flt_col;
    logic [SW-1:0]   cur_strat, nxt_strat, best_strat;
    logic [LW-1:0]   strat_len;
    logic            nxt_valid, row_ins, col_ins, restart, busy, done, unrep;
    logic [KW-1:0]   best_cost;
    logic [M*RW-1:0] sol_rows;
    logic [RCW-1:0]  sol_rcnt;
    logic [N*CW-1:0] sol_cols;
    logic [CCW-1:0]  sol_ccnt;
    logic [7:0]      fl [16];
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    sa_solver #(.M(M), .N(N), .RW(RW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .mr_rows(mr_rows), .mr_rcnt(mr_rcnt), .mr_cols(mr_cols), .mr_ccnt(mr_ccnt),
        .flt_cnt(flt_cnt), .flt_idx(flt_idx), .flt_row(flt_row), .flt_col(flt_col),
        .cur_strat(cur_strat), .strat_len(strat_len),
        .nxt_strat(nxt_strat), .nxt_valid(nxt_valid),
        .row_ins(row_ins), .col_ins(col_ins), .restart(restart),
        .busy(busy), .done(done), .unrep(unrep),
        .best_cost(best_cost), .best_strat(best_strat),
        .sol_rows(sol_rows), .sol_rcnt(sol_rcnt), .sol_cols(sol_cols), .sol_ccnt(sol_ccnt)
    );

    always_comb begin
        flt_row = fl[flt_idx][7:4];
        flt_col = fl[flt_idx][3:0];
    end

    // enumerator model: next larger word with the same number of 1 bits
    always_comb begin
        int s, c, r, nx, ones;
        s = int'(cur_strat);
        ones = $countones(cur_strat);
        nxt_valid = 1'b0;
        nxt_strat = '0;
        if (ones != 0 && ones != int'(strat_len)) begin
            c = s & (-s);
            r = s + c;
            nx = (((r ^ s) >> 2) / c) | r;
            if (nx < (1 << int'(strat_len))) begin
                nxt_valid = 1'b1;
                nxt_strat = SW'(nx);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit on_mr_row(int v, logic [3:0] a);
        for (int j = 0; j < VRC[v]; j++) if (VMR[v][j*4 +: 4] == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit on_mr_col(int v, logic [3:0] a);
        for (int j = 0; j < VCC[v]; j++) if (VMC[v][j*4 +: 4] == a) return 1'b1;
        return 1'b0;
    endfunction

    // exhaustive minimum over row and column subsets
    function automatic int brute(int v);
        logic [3:0] rl [8];
        logic [3:0] cl [8];
        int nr = 0, nc = 0, best = -1;
        for (int e = 0; e < VN[v]; e++) begin
            logic [3:0] r, c;
            bit fr, fc;
            r = VF[v][e*8+4 +: 4];
            c = VF[v][e*8 +: 4];
            if (on_mr_row(v, r) || on_mr_col(v, c)) continue;
            fr = 0; fc = 0;
            for (int k = 0; k < nr; k++) if (rl[k] == r) fr = 1;
            for (int k = 0; k < nc; k++) if (cl[k] == c) fc = 1;
            if (!fr) begin rl[nr] = r; nr++; end
            if (!fc) begin cl[nc] = c; nc++; end
        end
        for (int rm = 0; rm < (1 << nr); rm++)
            for (int cm = 0; cm < (1 << nc); cm++) begin
                int pr, pc;
                bit ok;
                pr = $countones(rm);
                pc = $countones(cm);
                if (VRC[v] + pr > M || VCC[v] + pc > N) continue;
                ok = 1;
                for (int e = 0; e < VN[v]; e++) begin
                    logic [3:0] r, c;
                    bit cov;
                    r = VF[v][e*8+4 +: 4];
                    c = VF[v][e*8 +: 4];
                    cov = on_mr_row(v, r) || on_mr_col(v, c);
                    for (int k = 0; k < nr; k++) if (rm[k] && rl[k] == r) cov = 1;
                    for (int k = 0; k < nc; k++) if (cm[k] && cl[k] == c) cov = 1;
                    if (!cov) ok = 0;
                end
                if (ok && (best < 0 || VRC[v] + VCC[v] + pr + pc < best))
                    best = VRC[v] + VCC[v] + pr + pc;
            end
        return best;
    endfunction

    // replays one strategy word without pruning; returns cost or -1
    function automatic int replay(int v, logic [SW-1:0] s, int len);
        logic [3:0] rr [M];
        logic [3:0] cc [N];
        int nr = 0, nc = 0, k = 0;
        for (int e = 0; e < VN[v]; e++) begin
            logic [3:0] r, c;
            bit cov, sy;
            r = VF[v][e*8+4 +: 4];
            c = VF[v][e*8 +: 4];
            cov = on_mr_row(v, r) || on_mr_col(v, c);
            for (int j = 0; j < nr; j++) if (rr[j] == r) cov = 1;
            for (int j = 0; j < nc; j++) if (cc[j] == c) cov = 1;
            if (cov) continue;
            sy = (k < len) ? s[k] : 1'b1;
            if (sy) begin
                if (VRC[v] + nr >= M) return -1;
                rr[nr] = r; nr++;
            end else begin
                if (VCC[v] + nc >= N) return -1;
                cc[nc] = c; nc++;
            end
            k++;
        end
        return VRC[v] + VCC[v] + nr + nc;
    endfunction

    task automatic run_vec(input int v);
        int fr, fcc, exp, bf, k, seg, t, cost;
        bit pend, in_rec;
        for (int e = 0; e < 16; e++) fl[e] = (e < 8) ? VF[v][e*8 +: 8] : 8'h0;
        mr_rows = VMR[v];
        mr_rcnt = RCW'(VRC[v]);
        mr_cols = VMC[v];
        mr_ccnt = CCW'(VCC[v]);
        flt_cnt = FW'(VN[v]);
        fr = M - VRC[v];
        fcc = N - VCC[v];
        exp = VEXP[v];
        bf = brute(v);
        chk(bf == exp, "R9 table vs exhaustive search", bf, exp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: first strategy sized by the free spares, row symbols low
        chk(int'(strat_len) == fr + fcc, "R2 strategy length", int'(strat_len), fr + fcc);
        chk(int'(cur_strat) == (1 << fr) - 1, "R2 first strategy", int'(cur_strat), (1 << fr) - 1);
        k = 0; seg = 0; t = 0; pend = 0; in_rec = 0;
        while (!done && t < 500) begin
            if (pend) begin
                chk(int'(sol_rcnt) == VRC[v], "R11 rows restored", int'(sol_rcnt), VRC[v]);
                chk(int'(sol_ccnt) == VCC[v], "R11 cols restored", int'(sol_ccnt), VCC[v]);
                chk(flt_idx == '0, "R4 read index rewound", int'(flt_idx), 0);
                pend = 0;
            end
            if (busy) begin
                seg++;
                if (row_ins || col_ins) begin
                    bit er;
                    er = (k < int'(strat_len)) ? cur_strat[k] : 1'b1;
                    chk(row_ins == er && col_ins == !er, "R3 insert follows symbol",
                        int'(row_ins), int'(er));
                    cost = int'(sol_rcnt) + int'(sol_ccnt) + 1;
                    if (!in_rec)
                        chk(cost < int'(best_cost), "R5 insert below best", cost, int'(best_cost));
                    k++;
                end
                if (restart) begin
                    chk(seg <= VN[v] + 1, "R7 strategy cycles", seg, VN[v] + 1);
                    if (!nxt_valid) in_rec = 1;
                    seg = 0; k = 0; pend = 1;
                end
            end
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R10 completion", int'(done), 1);
        chk(unrep == (exp < 0), "R10 unrepairable flag", int'(unrep), int'(exp < 0));
        if (exp >= 0) begin
            bit all_cov, mr_ok;
            chk(int'(best_cost) == exp, "R9 minimum cost", int'(best_cost), exp);
            cost = replay(v, best_strat, int'(strat_len));
            chk(cost == int'(best_cost), "R6 best word reproduces cost", cost, int'(best_cost));
            chk(int'(sol_rcnt) + int'(sol_ccnt) == exp, "R8 record size",
                int'(sol_rcnt) + int'(sol_ccnt), exp);
            all_cov = 1;
            for (int e = 0; e < VN[v]; e++) begin
                bit cov;
                cov = 0;
                for (int j = 0; j < int'(sol_rcnt); j++)
                    if (sol_rows[j*RW +: RW] == VF[v][e*8+4 +: 4]) cov = 1;
                for (int j = 0; j < int'(sol_ccnt); j++)
                    if (sol_cols[j*CW +: CW] == VF[v][e*8 +: 4]) cov = 1;
                if (!cov) all_cov = 0;
            end
            chk(all_cov, "R8 record covers all faults", int'(all_cov), 1);
            mr_ok = 1;
            for (int j = 0; j < VRC[v]; j++)
                if (sol_rows[j*RW +: RW] != VMR[v][j*4 +: 4]) mr_ok = 0;
            for (int j = 0; j < VCC[v]; j++)
                if (sol_cols[j*CW +: CW] != VMC[v][j*4 +: 4]) mr_ok = 0;
            chk(mr_ok, "R8 must-repair entries kept", int'(mr_ok), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        chk(!busy && !done && !unrep, "R1 idle flags", int'({busy, done, unrep}), 0);
        chk(!restart && !row_ins && !col_ins, "R1 quiet strobes",
            int'({restart, row_ins, col_ins}), 0);
        for (int v = 0; v < NV; v++) begin
            run_vec(v);
            @(negedge clk);
        end
        // R1: reset in mid-search returns to idle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1 reset during search", int'({busy, done}), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule